// File: doc/BRIEF.md
# Clock-Gated One-Hot Row Selector

This block holds a single token in a 32-position circular register and drives it out as one-hot row-select lines for a small memory array, so that exactly one row is active in any cycle. The token steps one position toward the higher bit on each clock edge where `advance` is high. After the top position it wraps back to position 0.

The register is split into two 16-bit segments, and each segment has its own clock. That clock is the free-running clock ANDed with a latched enable. Only the segment that holds the token gets clock edges. On the single edge where the token crosses from one segment into the other, both segments are clocked so that the handoff completes. Each latched enable is brought out as a port so that the gating can be observed. The asynchronous reset is synchronised on release. While reset is active, both segments are clocked so that the token is reloaded into position 0.

Top module: `row_token_ring`

## Requirements
- R1: Outside reset, `row_sel` has exactly one bit set in every cycle.
- R2: After reset has been released and has propagated, `row_sel` equals 32'h0000_0001. With the token in position 0 and no handoff pending, `seg_clk_en` equals 2'b01.
- R3: On a rising `clk` edge with `advance` high, the token moves from position i to position i+1. Position 31 wraps to position 0.
- R4: On a rising `clk` edge with `advance` low, `row_sel` does not change.
- R5: `seg_clk_en[0]` serves positions 0 to 15 and `seg_clk_en[1]` serves positions 16 to 31. The enable of the segment holding the token is high for the coming edge.
- R6: When the token is at position 15 or 31 and `advance` is high, both bits of `seg_clk_en` are high for that edge, and the token enters the other segment.
- R7: In every other cycle, the enable of the segment without the token is low, and that segment's row-select bits stay unchanged.
- R8: Driving `rst_n` low forces `row_sel` to position 0 at once, without waiting for a clock edge. After `rst_n` rises, the first two `clk` edges leave the token in position 0 even when `advance` is high, and the third edge advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| advance | input | 1 | Step the token one position on this edge |
| row_sel | output | 32 | One-hot row-select lines |
| seg_clk_en | output | 2 | Latched gate enables; bit 0 is the lower segment, bit 1 the upper |

## Verification
The hardest case to reach is the segment handoff. The token has to sit exactly on position 15 or 31 with `advance` high, and this is the only moment when both gates open together. The stimulus table counts out runs of advances that are sized to land on both boundaries. It holds the token there with `advance` low, so the bench can confirm that only one gate opens. It then takes the crossing edge, and continues through the wrap from position 31 back to position 0. Reset is also asserted while the clock is high with the token at a mid position, to show that the token returns at once and that release takes the expected number of edges.

// File: rtl/rts_pkg.sv
package rts_pkg;
  // Default geometry of the row selector.
  localparam int unsigned RTS_ROWS        = 32;
  localparam int unsigned RTS_SEGS        = 2;
  // Flops in the reset-release synchroniser.
  localparam int unsigned RTS_SYNC_STAGES = 2;
endpackage

// File: rtl/rts_reset_sync.sv
module rts_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rts_clock_gate.sv
// Latch-then-AND gate: the enable may change only while clk is low, so the
// gated clock has no partial pulses.
module rts_clock_gate (
  input  logic clk,
  input  logic en,
  output logic en_latched,
  output logic gclk
);
  logic en_q;

  always_latch begin
    if (!clk) begin
      en_q <= en;
    end
  end

  assign gclk       = clk & en_q;
  assign en_latched = en_q;
endmodule

// File: rtl/rts_ring_segment.sv
module rts_ring_segment #(
  parameter int unsigned WIDTH       = 16,  // at least 2
  parameter bit          HOLDS_TOKEN = 1'b0
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             carry_in,
  output logic [WIDTH-1:0] seg_q
);
  localparam logic [WIDTH-1:0] RST_VAL = HOLDS_TOKEN ? WIDTH'(1) : '0;

  logic [WIDTH-1:0] seg_d;

  always_comb begin
    seg_d = {seg_q[WIDTH-2:0], carry_in};
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= RST_VAL;
    end else if (advance) begin
      seg_q <= seg_d;
    end
  end
endmodule

// File: rtl/row_token_ring.sv
module row_token_ring
  import rts_pkg::*;
#(
  parameter int unsigned ROWS = RTS_ROWS,
  parameter int unsigned SEGS = RTS_SEGS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [ROWS-1:0] row_sel,
  output logic [SEGS-1:0] seg_clk_en
);
  localparam int unsigned SEG_W = ROWS / SEGS;

  logic            rst_sync_n;
  logic [SEGS-1:0] seg_has;
  logic [SEGS-1:0] seg_tail;
  logic [SEGS-1:0] seg_en_raw;
  logic [SEGS-1:0] seg_gclk;

  rts_reset_sync #(.STAGES(RTS_SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    localparam int PREV = (s == 0) ? int'(SEGS) - 1 : s - 1;
    logic [SEG_W-1:0] seg_q;

    assign seg_has[s]  = |seg_q;
    assign seg_tail[s] = seg_q[SEG_W-1];
    // Clock this segment while it owns the token, while the token is about to
    // enter it, and throughout reset so the reset value is reloaded.
    assign seg_en_raw[s] = !rst_sync_n | seg_has[s] | (advance & seg_tail[PREV]);

    rts_clock_gate u_gate (
      .clk        (clk),
      .en         (seg_en_raw[s]),
      .en_latched (seg_clk_en[s]),
      .gclk       (seg_gclk[s])
    );

    rts_ring_segment #(
      .WIDTH       (SEG_W),
      .HOLDS_TOKEN (s == 0)
    ) u_seg (
      .gclk     (seg_gclk[s]),
      .rst_n    (rst_sync_n),
      .advance  (advance),
      .carry_in (seg_tail[PREV]),
      .seg_q    (seg_q)
    );

    assign row_sel[s*SEG_W +: SEG_W] = seg_q;
  end
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned SEGS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            advance,
  input logic [ROWS-1:0] row_sel,
  input logic [SEGS-1:0] seg_clk_en
);
  localparam int unsigned SEG_W = ROWS / SEGS;

  function automatic logic [ROWS-1:0] tail_mask();
    logic [ROWS-1:0] m;
    m = '0;
    for (int i = 0; i < int'(SEGS); i++) m[i*SEG_W + SEG_W - 1] = 1'b1;
    return m;
  endfunction

  localparam logic [ROWS-1:0] TAILS = tail_mask();

  logic at_tail;
  assign at_tail = |(row_sel & TAILS);

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1) else $error("one-hot lost"); // R1

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> row_sel == {$past(row_sel[ROWS-2:0]), $past(row_sel[ROWS-1])})
    else $error("bad step"); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(row_sel)) else $error("moved without advance"); // R4

  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && at_tail) |-> $countones(seg_clk_en) == 2)
    else $error("handoff gates"); // R6

  AST_SINGLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && at_tail) |-> $countones(seg_clk_en) == 1)
    else $error("extra gate open"); // R7

  for (genvar s = 0; s < SEGS; s++) begin : g_seg_chk
    AST_OWNER_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (|row_sel[s*SEG_W +: SEG_W]) |-> seg_clk_en[s])
      else $error("owner not clocked"); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_clk_en[s] |=> $stable(row_sel[s*SEG_W +: SEG_W]))
      else $error("gated segment changed"); // R7
  end
endmodule

bind row_token_ring rts_checker #(.ROWS(ROWS), .SEGS(SEGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .advance    (advance),
  .row_sel    (row_sel),
  .seg_clk_en (seg_clk_en)
);

// File: tb/test_row_token_ring.sv
`timescale 1ns/1ps
module test_row_token_ring;
  localparam int ROWS = 32;
  localparam int HALF = 16;

  typedef struct packed {
    logic       adv;
    logic [7:0] reps;
    logic [5:0] exp_idx;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 8'd14, 6'd15},
    '{1'b0, 8'd3,  6'd15},
    '{1'b1, 8'd1,  6'd16},
    '{1'b1, 8'd15, 6'd31},
    '{1'b0, 8'd2,  6'd31},
    '{1'b1, 8'd1,  6'd0},
    '{1'b1, 8'd20, 6'd20},
    '{1'b0, 8'd1,  6'd20},
    '{1'b1, 8'd11, 6'd31},
    '{1'b1, 8'd1,  6'd0}
  };

  logic            clk;
  logic            rst_n;
  logic            advance;
  logic [ROWS-1:0] row_sel;
  logic [1:0]      seg_clk_en;

  int checks;
  int fails;
  int idx;
  bit done;

  row_token_ring i_row_token_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .row_sel    (row_sel),
    .seg_clk_en (seg_clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_en(input int i, input logic adv);
    logic [1:0] e;
    e[0] = (i < HALF) || (i == ROWS - 1 && adv);
    e[1] = (i >= HALF) || (i == HALF - 1 && adv);
    return e;
  endfunction

  // Drive at negedge, sample late in the low phase, then take the edge.
  task automatic step(input logic adv);
    @(negedge clk);
    advance = adv;
    #8;
    chk($countones(row_sel) == 1, "R1 one-hot", row_sel, 32'(1) << idx);
    chk(row_sel == (32'(1) << idx), adv ? "R3 position" : "R4 position",
        row_sel, 32'(1) << idx);
    chk(seg_clk_en == exp_en(idx, adv),
        ((idx == HALF - 1 || idx == ROWS - 1) && adv) ? "R6 handoff gates" : "R5 R7 gates",
        32'(seg_clk_en), 32'(exp_en(idx, adv)));
    @(posedge clk);
    if (adv) idx = (idx + 1) % ROWS;
  endtask

  task automatic peek(input int exp_idx);
    @(negedge clk);
    advance = 1'b0;
    #8;
    chk(row_sel == (32'(1) << exp_idx), "R3 table end", row_sel, 32'(1) << exp_idx);
  endtask

  initial begin
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    idx     = 0;
    rst_n   = 1'b1;
    advance = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #8;
    chk(row_sel == 32'h1, "R2 token in reset", row_sel, 32'h1);

    // R8: release with advance high; two edges hold, the third moves.
    @(negedge clk);
    rst_n   = 1'b1;
    advance = 1'b1;
    @(posedge clk);
    @(negedge clk); #8;
    chk(row_sel == 32'h1, "R8 hold after edge 1", row_sel, 32'h1);
    @(posedge clk);
    @(negedge clk); #8;
    chk(row_sel == 32'h1, "R8 hold after edge 2", row_sel, 32'h1);
    chk(seg_clk_en == 2'b01, "R2 lower gate only", 32'(seg_clk_en), 32'h1);
    @(posedge clk);
    idx = 1;

    // Table walk.
    foreach (VECS[v]) begin
      for (int r = 0; r < int'(VECS[v].reps); r++) step(VECS[v].adv);
      peek(int'(VECS[v].exp_idx));
      chk(idx == int'(VECS[v].exp_idx), "R3 model vs table", idx, VECS[v].exp_idx);
    end

    // R8: asynchronous reset from a mid position, asserted while clk is high.
    for (int k = 0; k < 5; k++) step(1'b1);
    @(posedge clk);
    #5;
    advance = 1'b0;
    rst_n   = 1'b0;
    #1;
    chk(row_sel == 32'h1, "R8 immediate reset", row_sel, 32'h1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #8;
    chk(row_sel == 32'h1, "R2 token after release", row_sel, 32'h1);
    chk(seg_clk_en == 2'b01, "R2 gates after release", 32'(seg_clk_en), 32'h1);
    idx = 0;
    step(1'b0);
    step(1'b0);
    step(1'b1);
    step(1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule